// File: doc/BRIEF.md
# Signed Byte Multiply-Accumulate Lane Array

This block is a row of K independent lanes. Each lane multiplies a signed 8-bit operand by a signed 8-bit coefficient and adds a signed 32-bit seed. A single-cycle kick starts a run. Three operand vectors are sampled on that kick: A and B hold K bytes each, and the seed vector holds K 32-bit words. The coefficient vector then shifts past every lane, one element per cycle, and each lane's product register keeps only the last value it sees. Each run is one-shot, so every lane ends up holding the product with the final coefficient element, B[K-1].

Each lane's seed waits in a delay line of its own, 2K-1 stages deep. Every delay line carries its own valid shift chain, so no valid bit drives more than its neighbour stage and its data enable. When the seeds leave their delay lines, every lane adds its product and registers the sum. At the same moment a completion pulse goes high for one cycle.

The block has no memory or bus interface. It connects only through parallel vectors, the kick input and the completion output.

Top module: `mac_lane_array`

## Requirements
- R1: Synchronous active-high reset drives `done` low and every `out_vec` lane to zero. It also cancels any run in flight, so no completion pulse follows it.
- R2: Let the rising edge that samples the kick be edge 1. When `done` is high, lane i holds `acc_vec[i] + a_vec[i]*b_vec[K-1]`, taken modulo 2^32 with all operands signed. Here lane i is bits [8i+7:8i] of `a_vec` and `b_vec`, and bits [32i+31:32i] of `acc_vec` and `out_vec`. The other B elements have no effect.
- R3: `done` goes high in the cycle that follows rising edge 3K-2 counted from edge 1, which is edge 94 for K=32. It stays high for exactly one cycle.
- R4: If every A is zero, or every B is zero, each output equals its seed. If all inputs are zero, every output is zero.
- R5: With A=10, B=7 and seed 0 in every lane, every output is 70.
- R6: A kick that arrives while a run is in flight is ignored. The completion still arrives 3K-2 edges after the accepted kick, and no second completion follows.
- R7: `out_vec` changes only in the cycle where `done` is high, and it holds that value until the next completion.
- R8: Operand extremes are exact, for example -128 * -128 = 16384 and -128 * 127 = -16256. A sum that overflows 32 bits wraps around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick | input | 1 | One-cycle start pulse; ignored while busy |
| a_vec | input | K*8 | Signed operand per lane, held from the kick until done |
| b_vec | input | K*8 | Signed coefficient per lane; only the top element enters the result |
| acc_vec | input | K*32 | Signed seed per lane |
| out_vec | output | K*32 | Signed lane results |
| done | output | 1 | One-cycle completion pulse |

## Verification
Each result is due 3K-2 rising edges after the edge that samples the kick, which is 94 for K=32. The bench counts falling edges from the kick and requires `done` at exactly that count, then checks every lane in that same cycle. One cycle later it checks that `done` has dropped. Some cycles further on it checks that the outputs still hold the same values. It then watches for 100 more cycles after an ignored second kick, and for 120 cycles after a reset issued mid-run, to confirm that no stray completion appears.

// File: rtl/mac_lane_pkg.sv
package mac_lane_pkg;

    localparam int OP_W   = 8;
    localparam int ACC_W  = 32;
    localparam int PROD_W = 2 * OP_W;

    typedef logic signed [OP_W-1:0]   op_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic signed [PROD_W-1:0] prod_t;

    // A seed word together with the valid bit of its own delay line
    typedef struct packed {
        logic vld;
        acc_t data;
    } seed_t;

    function automatic prod_t op_mul(input op_t a, input op_t b);
        return a * b;
    endfunction

    function automatic acc_t lane_sum(input prod_t p, input acc_t s);
        return s + acc_t'(p);
    endfunction

endpackage

// File: rtl/mac_feed_ctrl.sv
module mac_feed_ctrl #(
    parameter int K = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    input  logic finish,
    output logic accept,
    output logic shift_en,
    output logic launch
);
    localparam int CW = (K > 2) ? $clog2(K) : 1;

    logic          busy_q;
    logic          feeding_q;
    logic [CW-1:0] cnt_q;

    assign accept   = kick && !busy_q;
    assign shift_en = feeding_q;
    // Seed enters stage 0 at edge K-1, so its tail lands on edge 3K-3
    assign launch   = feeding_q && (cnt_q == CW'(K - 3));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            feeding_q <= 1'b0;
            cnt_q     <= '0;
        end else if (accept) begin
            busy_q    <= 1'b1;
            feeding_q <= 1'b1;
            cnt_q     <= '0;
        end else begin
            if (feeding_q) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CW'(K - 2))
                    feeding_q <= 1'b0;
            end
            if (finish)
                busy_q <= 1'b0;
        end
    end

endmodule

// File: rtl/mac_seed_pipe.sv
module mac_seed_pipe
    import mac_lane_pkg::*;
#(
    parameter int DEPTH = 63
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_vld,
    input  acc_t  in_data,
    output seed_t tail
);
    logic [DEPTH-1:0] vld_q;
    acc_t             data_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else     vld_q <= {vld_q[DEPTH-2:0], in_vld};
    end

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (in_vld) data_q[0] <= in_data;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (vld_q[s-1]) data_q[s] <= data_q[s-1];
            end
        end
    end

    assign tail.vld  = vld_q[DEPTH-1];
    assign tail.data = data_q[DEPTH-1];

endmodule

// File: rtl/mac_lane.sv
module mac_lane
    import mac_lane_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  op_t   a_op,
    input  op_t   b_head,
    input  seed_t seed,
    output acc_t  res
);
    prod_t prod_q;
    acc_t  res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
            res_q  <= '0;
        end else begin
            prod_q <= op_mul(a_op, b_head);
            if (seed.vld)
                res_q <= lane_sum(prod_q, seed.data);
        end
    end

    assign res = res_q;

endmodule

// File: rtl/mac_lane_array.sv
module mac_lane_array
    import mac_lane_pkg::*;
#(
    parameter int K = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        kick,
    input  logic [K-1:0][OP_W-1:0]      a_vec,
    input  logic [K-1:0][OP_W-1:0]      b_vec,
    input  logic [K-1:0][ACC_W-1:0]     acc_vec,
    output logic [K-1:0][ACC_W-1:0]     out_vec,
    output logic                        done
);
    localparam int SEED_DEPTH = 2 * K - 1;

    logic  accept, shift_en, launch, finish;
    logic  done_q;
    op_t   a_q   [K];
    acc_t  acc_q [K];
    op_t   b_sr  [K];
    seed_t tail  [K];
    acc_t  res   [K];

    mac_feed_ctrl #(.K(K)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .kick     (kick),
        .finish   (finish),
        .accept   (accept),
        .shift_en (shift_en),
        .launch   (launch)
    );

    // Operand capture and coefficient shifter; head freezes at B[K-1]
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < K; j++) begin
                a_q[j]   <= '0;
                acc_q[j] <= '0;
                b_sr[j]  <= '0;
            end
        end else if (accept) begin
            for (int j = 0; j < K; j++) begin
                a_q[j]   <= a_vec[j];
                acc_q[j] <= acc_vec[j];
                b_sr[j]  <= b_vec[j];
            end
        end else if (shift_en) begin
            for (int j = 0; j < K - 1; j++)
                b_sr[j] <= b_sr[j+1];
        end
    end

    for (genvar g = 0; g < K; g++) begin : g_lane
        mac_seed_pipe #(.DEPTH(SEED_DEPTH)) u_pipe (
            .clk     (clk),
            .rst     (rst),
            .in_vld  (launch),
            .in_data (acc_q[g]),
            .tail    (tail[g])
        );

        mac_lane u_lane (
            .clk    (clk),
            .rst    (rst),
            .a_op   (a_q[g]),
            .b_head (b_sr[0]),
            .seed   (tail[g]),
            .res    (res[g])
        );

        assign out_vec[g] = res[g];
    end

    assign finish = tail[0].vld;

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= finish;
    end

    assign done = done_q;

endmodule

// File: rtl/mac_lane_array_chk.sv
module mac_lane_array_chk #(
    parameter int K = 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  kick,
    input logic                  done,
    input logic [K-1:0][7:0]     a_vec,
    input logic [K-1:0][7:0]     b_vec,
    input logic [K-1:0][31:0]    acc_vec,
    input logic [K-1:0][31:0]    out_vec
);
    localparam int LAT = 3 * K - 2;

    logic        run_q;
    logic [15:0] cyc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cyc_q <= '0;
        end else if (kick && (!run_q || done)) begin
            run_q <= 1'b1;
            cyc_q <= 16'd1;
        end else if (run_q) begin
            cyc_q <= cyc_q + 16'd1;
            if (done) run_q <= 1'b0;
        end
    end

    // R3: completion only at the due count
    a_r3_done_on_time: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_q && cyc_q == 16'(LAT)));

    // R3, R6: a due run always completes
    a_r3_done_when_due: assert property (@(posedge clk) disable iff (rst)
        (run_q && cyc_q == 16'(LAT)) |-> done);

    // R3: one-cycle pulse
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: outputs move only with a completion
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(out_vec));

    // R2: lane 0 formula with inputs held through the run
    a_r2_lane0: assert property (@(posedge clk) disable iff (rst)
        done |-> (out_vec[0] == 32'($signed(acc_vec[0]) +
                   $signed(a_vec[0]) * $signed(b_vec[K-1]))));

endmodule

bind mac_lane_array mac_lane_array_chk #(.K(K)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .kick    (kick),
    .done    (done),
    .a_vec   (a_vec),
    .b_vec   (b_vec),
    .acc_vec (acc_vec),
    .out_vec (out_vec)
);

// File: tb/tb_mac_lane_array.sv
`timescale 1ns/1ps
module tb_mac_lane_array;
    localparam int K   = 32;
    localparam int LAT = 3 * K - 2;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 kick = 1'b0;
    logic [K-1:0][7:0]    a_vec = '0;
    logic [K-1:0][7:0]    b_vec = '0;
    logic [K-1:0][31:0]   acc_vec = '0;
    logic [K-1:0][31:0]   out_vec;
    logic                 done;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    mac_lane_array #(.K(K)) dut (
        .clk(clk), .rst(rst), .kick(kick),
        .a_vec(a_vec), .b_vec(b_vec), .acc_vec(acc_vec),
        .out_vec(out_vec), .done(done)
    );

    function automatic logic [31:0] model(input logic [7:0] a, input logic [7:0] bl,
                                          input logic [31:0] s);
        int p;
        p = int'($signed(a)) * int'($signed(bl));
        return s + 32'(p);
    endfunction

    task automatic check(input bit ok, input string req, input longint got, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic check_lanes(input string req);
        int mism = 0;
        int first = -1;
        for (int i = 0; i < K; i++) begin
            if (out_vec[i] !== model(a_vec[i], b_vec[K-1], acc_vec[i])) begin
                mism++;
                if (first < 0) first = i;
            end
        end
        if (first < 0) check(1'b1, req, 0, 0);
        else check(1'b0, req, longint'($signed(out_vec[first])),
                   longint'($signed(model(a_vec[first], b_vec[K-1], acc_vec[first]))));
    endtask

    // Kick, wait for done, check R3 timing, lanes, pulse width and hold
    task automatic run_case(input string req, input bit rekick);
        int n;
        logic [K-1:0][31:0] snap;
        @(negedge clk);
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        n = 1;
        while (!done && n < 400) begin
            kick = (rekick && n == 40);
            @(negedge clk);
            n++;
        end
        kick = 1'b0;
        check(n == LAT, "R3 latency", n, LAT);
        check_lanes(req);
        snap = out_vec;
        @(negedge clk);
        check(done == 1'b0, "R3 pulse width", done, 0);
        repeat (8) @(negedge clk);
        check(out_vec == snap, "R7 hold", out_vec[0], snap[0]);
        if (rekick) begin
            int extra = 0;
            repeat (100) begin
                @(negedge clk);
                if (done) extra++;
            end
            check(extra == 0, "R6 ignored kick", extra, 0);
        end
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7391));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(done == 1'b0, "R1 done", done, 0);
        check(out_vec == '0, "R1 out", out_vec[0], 0);

        // R4: all zero
        run_case("R4 all zero", 1'b0);
        check(out_vec == '0, "R4 all zero out", out_vec[0], 0);

        // R4: A zero, B nonzero -> seeds
        for (int i = 0; i < K; i++) begin
            a_vec[i] = 8'd0; b_vec[i] = 8'(i + 3); acc_vec[i] = 32'(i * 1000 - 7);
        end
        run_case("R4 zero A", 1'b0);
        // R4: B zero -> seeds
        for (int i = 0; i < K; i++) begin
            a_vec[i] = 8'(i - 5); b_vec[i] = 8'd0; acc_vec[i] = 32'(-i * 77);
        end
        run_case("R4 zero B", 1'b0);
        check(out_vec[5] == acc_vec[5], "R4 zero B seed", out_vec[5], acc_vec[5]);

        // R5: 10 * 7 + 0
        for (int i = 0; i < K; i++) begin
            a_vec[i] = 8'd10; b_vec[i] = 8'd7; acc_vec[i] = 32'd0;
        end
        run_case("R5 ten by seven", 1'b0);
        check(out_vec[K-1] == 32'd70, "R5 value", out_vec[K-1], 70);

        // R8: extremes and wraparound
        for (int i = 0; i < K; i++) begin
            a_vec[i] = (i % 2) ? 8'h80 : 8'h7f;
            b_vec[i] = 8'h80;
            acc_vec[i] = (i == 3) ? 32'h7fff_ffff : 32'd0;
        end
        run_case("R8 extremes", 1'b0);
        check(out_vec[1] == 32'd16384, "R8 min times min", out_vec[1], 16384);
        check(out_vec[0] == 32'(-16256), "R8 max times min", $signed(out_vec[0]), -16256);

        // R6: second kick mid-run
        for (int i = 0; i < K; i++) begin
            a_vec[i] = 8'($urandom); b_vec[i] = 8'($urandom); acc_vec[i] = $urandom;
        end
        run_case("R6 rekick result", 1'b1);

        // R2: random patterns, other B elements differ per run
        for (int t = 0; t < 12; t++) begin
            for (int i = 0; i < K; i++) begin
                a_vec[i] = 8'($urandom); b_vec[i] = 8'($urandom); acc_vec[i] = $urandom;
            end
            run_case("R2 random lanes", 1'b0);
        end

        // R1: reset mid-run cancels completion and clears outputs
        @(negedge clk);
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        begin
            int seen = 0;
            repeat (120) begin
                @(negedge clk);
                if (done) seen++;
            end
            check(seen == 0, "R1 cancel", seen, 0);
        end
        check(out_vec == '0, "R1 cleared", out_vec[0], 0);

        // Array still usable after reset
        run_case("R2 after reset", 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule